// File: doc/BRIEF.md
# Dual-Bank Edge/Level Interrupt Controller

This block collects 64 interrupt inputs into two 32-bit banks and drives a single interrupt request to the processor. Each bank tracks the live level of its inputs and latches a rising edge as a pending event. A fixed per-bit flag marks some sources as level-type. A level-type source passes its live level straight to the request logic and never latches. An edge-type source is held pending until software clears it. Each bank has an enable mask. The processor request is raised whenever any enabled source, in either bank, is pending or is an asserted level-type source.

Software uses a plain 32-bit read/write register bus. Each bank exposes four word offsets: pending events (read), enable mask (read/write), event clear (write ones), and live levels (read). All inputs are sampled as levels on every clock. An edge is found by comparing each input with its value from the previous clock.

Top module: `dual_bank_irq_ctrl`

## Requirements
- R1: A bank requests when ((events OR (levels AND level_flags)) AND mask) is non-zero. `irq_out` is the OR of the two bank requests.
- R2: An input that goes from low to high sets its levels bit. It sets its events bit only when that bit's level flag is clear.
- R3: An input that goes low clears only its levels bit. A latched events bit stays set until software clears it.
- R4: Inputs 32..63 belong to bank 0 and inputs 0..31 to bank 1. The bit position is the input number modulo 32.
- R5: Only the low 12 address bits are decoded. The bank index is (addr[11:0] - 0x010) >> 4, so bank 0 is at 0x010 and bank 1 at 0x020. Any other index reads as zero and ignores writes.
- R6: Within a bank, offset 0x0 reads events, 0x4 reads and writes the mask, 0x8 is write-one-to-clear for events, and 0xC reads levels. Every other offset, including unaligned ones, reads zero and ignores writes. Writes to 0x0 and 0xC have no effect.
- R7: A value written to the clear offset is first ANDed with the inverse of the level flags, so a clear write never touches flagged bits. A clear write does not change the live level of a flagged source, so that source still drives the request.
- R8: After reset, events, mask and levels read zero in both banks and `irq_out` is low.
- R9: The level flags are constant, with bank 0 = 0x00000000 and bank 1 = 0x1FF00000 (inputs 20..28 are level-type). No bus write changes them.
- R10: When an edge-type input rises in the same cycle as a clear write to its bit, the events bit ends up set.
- R11: An input that stays high produces exactly one event. A new event needs the input to go low and then rise again.
- R12: `irq_out` is registered. It changes on the clock edge that captures the input change, mask write or clear write that causes it, so it appears one clock after that stimulus is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Register byte address; only bits 11:0 are decoded |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_src | input | 64 | Interrupt source levels, input n on bit n |
| irq_out | output | 1 | Registered interrupt request to the processor |

## Verification
The bench builds the block with its default parameters: two 32-bit banks, a 16-bit address, bank base 0x010, and level flags 0x00000000 for bank 0 and 0x1FF00000 for bank 1. These defaults put edge-type and level-type sources in the same bank (bank 1, inputs 3, 20 and 21), so the masked clear and the level pass-through can be compared side by side. Bank 0 bit 20 (input 52) is an edge-type source at the same bit position as a flagged bank 1 bit, which shows that the flags are per bank. The 16-bit address lets the bench check that bits above bit 11 are ignored, and that indices below the base and past the last bank are rejected.

// File: rtl/irqc_pkg.sv
// Package: shared register-operation encoding for the interrupt controller.
// Assumes word offsets 0x0/0x4/0x8/0xC within a bank map onto addr[3:2].
package irqc_pkg;

    // Register operation selected by addr[3:2] inside a bank window.
    typedef enum logic [1:0] {
        REG_EVENTS = 2'd0,
        REG_MASK   = 2'd1,
        REG_CLEAR  = 2'd2,
        REG_LEVELS = 2'd3
    } reg_op_e;

    // Number of low address bits that are decoded at all.
    localparam int DECODE_BITS = 12;

    // Address bits that select one register inside a bank window.
    localparam int WINDOW_SHIFT = 4;

endpackage

// File: rtl/irqc_bus_decode.sv
// Module: irqc_bus_decode
// Turns a byte address into a one-hot bank select and a register operation.
// Assumes only the low DECODE_BITS address bits count, that bank windows are
// 16 bytes wide starting at BASE_OFF, and that unaligned offsets hit nothing.
module irqc_bus_decode
    import irqc_pkg::*;
#(
    parameter int                     ADDR_W    = 16,
    parameter int                     NUM_BANKS = 2,
    parameter logic [DECODE_BITS-1:0] BASE_OFF  = 12'h010
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_BANKS-1:0] bank_sel,
    output reg_op_e              op
);

    localparam int IDX_W = DECODE_BITS - WINDOW_SHIFT;

    logic [DECODE_BITS-1:0] rel_addr;
    logic [IDX_W-1:0]       bank_idx;
    logic                   aligned;
    logic                   unused_addr_bits;

    // Offset relative to the first bank window; wraps for addresses below it.
    assign rel_addr = addr[DECODE_BITS-1:0] - BASE_OFF;
    assign bank_idx = rel_addr[DECODE_BITS-1:WINDOW_SHIFT];
    assign aligned  = (addr[1:0] == 2'b00);
    assign op       = reg_op_e'(addr[3:2]);

    // Bits above the decoded range and the window-local part of rel_addr are unused.
    assign unused_addr_bits = ^{addr[ADDR_W-1:DECODE_BITS], rel_addr[WINDOW_SHIFT-1:0]};

    // One select per bank, raised only for an aligned access in its window.
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            bank_sel[b] = aligned && (bank_idx == IDX_W'(b));
        end
    end

    // R5: at most one bank is ever selected.
    always_comb begin
        p_single_bank_r5: assert ($onehot0(bank_sel));
    end

endmodule

// File: rtl/irqc_bank.sv
// Module: irqc_bank
// One bank: live levels, latched edge events, an enable mask, and fixed
// level-type flags. Edges are found against the registered levels.
// Assumes wr_mask and wr_clear are already qualified for this bank and are
// never high together. Provides the request for the current state and for
// the state about to be loaded.
module irqc_bank #(
    parameter int               WIDTH     = 32,
    parameter logic [WIDTH-1:0] LVL_FLAGS = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] src,
    input  logic             wr_mask,
    input  logic             wr_clear,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] events_q,
    output logic [WIDTH-1:0] mask_q,
    output logic [WIDTH-1:0] levels_q,
    output logic             req_now,
    output logic             req_next
);

    logic [WIDTH-1:0] rise;
    logic [WIDTH-1:0] clr_bits;
    logic [WIDTH-1:0] events_d;
    logic [WIDTH-1:0] mask_d;

    // Rising edges: the input is high now and was low at the last edge.
    assign rise = src & ~levels_q;

    // Clear request with the level-type bits protected.
    assign clr_bits = wr_clear ? (wdata & ~LVL_FLAGS) : '0;

    // Next events: clear first, then set, so a new edge wins over a clear.
    assign events_d = (events_q & ~clr_bits) | (rise & ~LVL_FLAGS);

    // Next mask: a bus write replaces it.
    assign mask_d = wr_mask ? wdata : mask_q;

    // Request computed from the registered state.
    assign req_now  = |((events_q | (levels_q & LVL_FLAGS)) & mask_q);

    // Request computed from the state loaded at the coming edge.
    assign req_next = |((events_d | (src & LVL_FLAGS)) & mask_d);

    // State registers with synchronous reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            events_q <= '0;
            mask_q   <= '0;
            levels_q <= '0;
        end else begin
            events_q <= events_d;
            mask_q   <= mask_d;
            levels_q <= src;
        end
    end

    // R2: levels follow the sampled inputs one clock later.
    p_levels_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (levels_q == $past(src)));

    // R2/R10: an edge on an edge-type bit leaves its event set, clear or not.
    p_rise_sets_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(src & ~levels_q & ~LVL_FLAGS)) |=>
        ((events_q & $past(src & ~levels_q & ~LVL_FLAGS)) == $past(src & ~levels_q & ~LVL_FLAGS)));

    // R3: without a clear write, no latched event ever drops.
    p_event_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_clear |=> ((events_q & $past(events_q)) == $past(events_q)));

    // R6: without a mask write the mask is stable.
    p_mask_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mask |=> $stable(mask_q));

endmodule

// File: rtl/dual_bank_irq_ctrl.sv
// Module: dual_bank_irq_ctrl (top)
// Two interrupt banks behind a simple register bus, feeding one registered
// request line. Bank b takes the input slice (NUM_BANKS-1-b), so higher input
// numbers land in lower banks. Level flags are fixed per bank by parameter.
// Assumes single-cycle writes and a combinational read path.
module dual_bank_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int                             ADDR_W    = 16,
    parameter int                             BANK_W    = 32,
    parameter int                             NUM_BANKS = 2,
    parameter logic [DECODE_BITS-1:0]         BASE_OFF  = 12'h010,
    parameter logic [NUM_BANKS*BANK_W-1:0]    LVL_FLAGS = {32'h1FF0_0000, 32'h0000_0000}
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_we,
    input  logic [BANK_W-1:0]           bus_wdata,
    output logic [BANK_W-1:0]           bus_rdata,
    input  logic [NUM_BANKS*BANK_W-1:0] irq_src,
    output logic                        irq_out
);

    logic [NUM_BANKS-1:0] bank_sel;
    reg_op_e              op;
    logic [BANK_W-1:0]    events_arr [NUM_BANKS];
    logic [BANK_W-1:0]    mask_arr   [NUM_BANKS];
    logic [BANK_W-1:0]    levels_arr [NUM_BANKS];
    logic [NUM_BANKS-1:0] req_now;
    logic [NUM_BANKS-1:0] req_next;
    logic                 irq_q;

    // Address decode into bank select and operation.
    irqc_bus_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_BANKS (NUM_BANKS),
        .BASE_OFF  (BASE_OFF)
    ) u_decode (
        .addr     (bus_addr),
        .bank_sel (bank_sel),
        .op       (op)
    );

    // One bank instance per bank index, fed its reversed input slice.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic wr_mask_b;
        logic wr_clear_b;

        // Write strobes qualified by bank select and operation.
        assign wr_mask_b  = bus_we && bank_sel[b] && (op == REG_MASK);
        assign wr_clear_b = bus_we && bank_sel[b] && (op == REG_CLEAR);

        irqc_bank #(
            .WIDTH     (BANK_W),
            .LVL_FLAGS (LVL_FLAGS[b*BANK_W +: BANK_W])
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .src      (irq_src[(NUM_BANKS-1-b)*BANK_W +: BANK_W]),
            .wr_mask  (wr_mask_b),
            .wr_clear (wr_clear_b),
            .wdata    (bus_wdata),
            .events_q (events_arr[b]),
            .mask_q   (mask_arr[b]),
            .levels_q (levels_arr[b]),
            .req_now  (req_now[b]),
            .req_next (req_next[b])
        );
    end

    // Read mux: the selected bank's register, or zero for the clear offset and misses.
    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_sel[b]) begin
                unique case (op)
                    REG_EVENTS: bus_rdata = events_arr[b];
                    REG_MASK:   bus_rdata = mask_arr[b];
                    REG_LEVELS: bus_rdata = levels_arr[b];
                    default:    bus_rdata = '0;
                endcase
            end
        end
    end

    // Output register loaded from the next-state request of all banks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |req_next;
        end
    end

    assign irq_out = irq_q;

    // R1/R12: the registered output agrees with the bank state it was loaded with.
    p_out_matches_banks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (|req_now));

    // R6: a read of the clear offset returns zero.
    p_clear_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == REG_CLEAR) |-> (bus_rdata == '0));

endmodule

// File: tb/test_dual_bank_irq_ctrl.sv
// Scoreboard bench: driver tasks queue expected values; a monitor on the
// falling edge pops and compares them against bus_rdata or irq_out.
module test_dual_bank_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] irq_src = '0;
    logic        irq_out;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];

    always #2.5 clk = ~clk;

    dual_bank_irq_ctrl i_dual_bank_irq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_src   (irq_src),
        .irq_out   (irq_out)
    );

    // Monitor: compare one queued expectation per falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = it.is_irq ? {31'b0, irq_out} : bus_rdata;
                tests++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk_reg(input logic [15:0] a, input logic [31:0] e, input string tag);
        bus_addr = a;
        sb_q.push_back('{1'b0, e, tag});
        tick();
    endtask

    task automatic chk_irq(input logic e, input string tag);
        sb_q.push_back('{1'b1, {31'b0, e}, tag});
        tick();
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        tick();
        bus_we    = 1'b0;
    endtask

    task automatic set_src(input int n, input logic v);
        irq_src[n] = v;
        tick();
    endtask

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        #1000000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R8: reset state
        chk_reg(16'h010, 32'h0, "R8 b0 events");
        chk_reg(16'h014, 32'h0, "R8 b0 mask");
        chk_reg(16'h01C, 32'h0, "R8 b0 levels");
        chk_reg(16'h020, 32'h0, "R8 b1 events");
        chk_reg(16'h024, 32'h0, "R8 b1 mask");
        chk_reg(16'h02C, 32'h0, "R8 b1 levels");
        chk_irq(1'b0, "R8 irq");

        // R4/R2: input 40 -> bank 0 bit 8
        set_src(40, 1'b1);
        chk_reg(16'h010, 32'h0000_0100, "R4 b0 event bit8");
        chk_reg(16'h01C, 32'h0000_0100, "R2 b0 level bit8");
        chk_reg(16'h020, 32'h0, "R4 b1 untouched");
        chk_irq(1'b0, "R1 masked off");

        // R1: enabling the mask raises the request
        wr(16'h014, 32'h0000_0100);
        chk_irq(1'b1, "R1 enabled event");
        chk_reg(16'h014, 32'h0000_0100, "R6 mask readback");

        // R3: fall keeps the event
        set_src(40, 1'b0);
        chk_reg(16'h01C, 32'h0, "R3 level cleared");
        chk_reg(16'h010, 32'h0000_0100, "R3 event kept");
        chk_irq(1'b1, "R3 irq kept");

        // R7: write-one-to-clear
        wr(16'h018, 32'h0000_0100);
        chk_reg(16'h010, 32'h0, "R7 event cleared");
        chk_irq(1'b0, "R7 irq dropped");

        // R11: held-high input makes one event only
        set_src(40, 1'b1);
        wr(16'h018, 32'h0000_0100);
        tick();
        chk_reg(16'h010, 32'h0, "R11 no re-latch while high");
        set_src(40, 1'b0);
        set_src(40, 1'b1);
        chk_reg(16'h010, 32'h0000_0100, "R11 new edge latches");
        set_src(40, 1'b0);
        wr(16'h018, 32'h0000_0100);
        chk_irq(1'b0, "R11 idle");

        // R2: level-type input 20 -> bank 1 bit 20, no event
        set_src(20, 1'b1);
        chk_reg(16'h02C, 32'h0010_0000, "R2 b1 level bit20");
        chk_reg(16'h020, 32'h0, "R2 flagged bit no event");
        // R12: mask write shows on irq one clock later
        bus_addr  = 16'h024;
        bus_wdata = 32'h0010_0000;
        bus_we    = 1'b1;
        chk_irq(1'b0, "R12 before mask edge");
        bus_we    = 1'b0;
        chk_irq(1'b1, "R12 after mask edge");
        // R7: clear of all ones leaves level source driving
        wr(16'h028, 32'hFFFF_FFFF);
        chk_irq(1'b1, "R7 level source survives clear");
        set_src(20, 1'b0);
        chk_irq(1'b0, "R1 level pass-through drops");
        chk_reg(16'h02C, 32'h0, "R3 b1 level cleared");

        // R7: edge-type bit in bank 1 does clear
        set_src(3, 1'b1);
        chk_reg(16'h020, 32'h0000_0008, "R4 input3 -> b1 bit3");
        set_src(3, 1'b0);
        wr(16'h028, 32'hFFFF_FFFF);
        chk_reg(16'h020, 32'h0, "R7 edge bit cleared in b1");

        // R6/R9: writes to read-only offsets ignored; flags fixed
        wr(16'h020, 32'hFFFF_FFFF);
        wr(16'h02C, 32'hFFFF_FFFF);
        chk_reg(16'h020, 32'h0, "R6 events write ignored");
        chk_reg(16'h02C, 32'h0, "R6 levels write ignored");
        set_src(21, 1'b1);
        chk_reg(16'h020, 32'h0, "R9 b1 bit21 still level-type");
        chk_reg(16'h02C, 32'h0020_0000, "R9 b1 bit21 level");
        set_src(21, 1'b0);
        set_src(52, 1'b1);
        chk_reg(16'h010, 32'h0010_0000, "R9 b0 bit20 edge-type");
        set_src(52, 1'b0);
        wr(16'h018, 32'h0010_0000);
        chk_reg(16'h010, 32'h0, "R9 b0 bit20 cleared");

        // R5: decode range and ignored upper bits
        wr(16'h034, 32'hFFFF_FFFF);
        wr(16'h004, 32'hFFFF_FFFF);
        chk_reg(16'h014, 32'h0000_0100, "R5 b0 mask untouched");
        chk_reg(16'h024, 32'h0010_0000, "R5 b1 mask untouched");
        chk_reg(16'h034, 32'h0, "R5 index 2 reads zero");
        chk_reg(16'h004, 32'h0, "R5 below base reads zero");
        chk_reg(16'h1014, 32'h0000_0100, "R5 upper bits ignored");
        chk_reg(16'h018, 32'h0, "R6 clear offset reads zero");
        chk_reg(16'h015, 32'h0, "R6 unaligned reads zero");
        wr(16'h016, 32'h0);
        chk_reg(16'h014, 32'h0000_0100, "R6 unaligned write ignored");

        // R10: rise and clear in the same cycle keeps the event
        set_src(33, 1'b1);
        set_src(33, 1'b0);
        chk_reg(16'h010, 32'h0000_0002, "R10 setup event");
        irq_src[33] = 1'b1;
        wr(16'h018, 32'h0000_0002);
        chk_reg(16'h010, 32'h0000_0002, "R10 set wins over clear");
        set_src(33, 1'b0);
        wr(16'h018, 32'h0000_0002);
        chk_reg(16'h010, 32'h0, "R10 later clear works");

        // R12: input and clear latency
        irq_src[40] = 1'b1;
        chk_irq(1'b0, "R12 before input edge");
        chk_irq(1'b1, "R12 after input edge");
        set_src(40, 1'b0);
        bus_addr  = 16'h018;
        bus_wdata = 32'h0000_0100;
        bus_we    = 1'b1;
        chk_irq(1'b1, "R12 before clear edge");
        bus_we    = 1'b0;
        chk_irq(1'b0, "R12 after clear edge");

        tick();
        tick();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule